// File: doc/BRIEF.md
# Byte-lane set/clear command register bank

This block holds a small bank of 32-bit control registers that software updates without read-modify-write. A write never replaces a register's contents. Each byte of the write word is an independent instruction: its most significant bit is the value to apply, and its lower seven bits select which of the eight bits in that lane receive the value. Register bits whose select bit is zero keep their state, so two agents can set and clear different bits of one register without a shared lock.

The bank sits behind a single-cycle memory-mapped port with a byte address, write enable, per-byte strobes, write data and a combinational read-data output. Five registers are decoded at byte offsets 0x40, 0x48, 0x50, 0x54 and 0x64. Each register has its own mask of implemented bits, its own reset value and its own set of self-clearing pulse bits, all given as parameters. A pulse bit reads as 1 for exactly one cycle after it is set, then falls back to 0 by itself. This is the usual shape for "go" commands that hardware latches once.

Top module: `sc_cmd_bank`

## Requirements
- R1: After reset every register reads 0, given the default all-zero reset values.
- R2: When a strobed byte lane has bit 7 set, each lane bit among bits 6:0 that is 1 sets the matching register bit. Writing 0x9A to lane 0 sets bits 1, 3 and 4.
- R3: When a strobed byte lane has bit 7 clear, each selected bit is cleared. Writing 0x1A to lane 0 clears bits 1, 3 and 4.
- R4: Bits whose select is 0 keep their value. The four lanes of one write act independently, each lane with its own value bit.
- R5: A lane whose strobe (bus_be[n] for bits 8n+7:8n) is low changes nothing, whatever its data bits hold.
- R6: Only implemented bits can change or read as 1. The masks are 0x1F7F7F1F at 0x40, 0x000F0F7F at 0x48, 0x3F7F3F7F at 0x50, 0x203C7E07 at 0x54 and 0x0000001B at 0x64.
- R7: Read data bits 7, 15, 23 and 31 are always 0.
- R8: Writing a register's full mask with all value bits at 0 clears every implemented bit of that register.
- R9: Pulse bits (bits 16 and 11:8 at 0x48 by default) read 1 in the cycle after they are set, and read 0 one cycle later unless they are written again. Non-pulse bits of the same register stay set.
- R10: A write that lands in the cycle a pulse bit expires is applied in full. A pulse bit that is set again in that cycle stays at 1.
- R11: A write to an unmapped address changes no register. A read of an unmapped address returns 0.
- R12: A write reaches only the register at its address. The other four are untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write enable for this cycle |
| bus_addr | input | 8 | Byte address for read and write |
| bus_be | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data, four value/select lanes |
| bus_rdata | output | 32 | Combinational read data of the addressed register |

## Verification
The interesting coincidence is a pulse bit expiring in the same cycle that a new write lands on its register. The bench sets a pulse bit and, in the very next cycle, writes a different bit of the same register while also reading it. The read must still show the pulse bit, and the following read must show the pulse bit gone and the new bit present. In a second case the bench sets the same pulse bit again in its expiry cycle and expects it to survive exactly one more cycle.

// File: rtl/sc_cmd_pkg.sv
`timescale 1ns/1ps
package sc_cmd_pkg;

    localparam int SC_NREG = 5;
    localparam int SC_DW   = 32;
    localparam int SC_AW   = 8;

    // index 0 is the rightmost element of each concatenation
    localparam logic [SC_NREG-1:0][SC_AW-1:0] SC_DEF_OFFS =
        {8'h64, 8'h54, 8'h50, 8'h48, 8'h40};

    localparam logic [SC_NREG-1:0][SC_DW-1:0] SC_DEF_MASK =
        {32'h0000_001B, 32'h203C_7E07, 32'h3F7F_3F7F, 32'h000F_0F7F, 32'h1F7F_7F1F};

    localparam logic [SC_NREG-1:0][SC_DW-1:0] SC_DEF_PULSE =
        {32'h0, 32'h0, 32'h0, 32'h0001_0F00, 32'h0};

    localparam logic [SC_NREG-1:0][SC_DW-1:0] SC_DEF_RSTV = '0;

    // positions of the per-lane value bits in a data word
    function automatic logic [SC_DW-1:0] sc_value_bits();
        logic [SC_DW-1:0] m;
        m = '0;
        for (int l = 0; l < SC_DW/8; l++) m[8*l+7] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/sc_lane_decode.sv
`timescale 1ns/1ps
module sc_lane_decode #(
    parameter int DW = 32,
    localparam int LANES = DW/8
) (
    input  logic             wr_live,
    input  logic [LANES-1:0] lane_stb,
    input  logic [DW-1:0]    lane_data,
    output logic [DW-1:0]    set_bits,
    output logic [DW-1:0]    clr_bits
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic       act;
        logic       val;
        logic [6:0] sel;
        assign act = wr_live & lane_stb[l];
        assign val = lane_data[8*l+7];
        assign sel = lane_data[8*l +: 7];
        assign set_bits[8*l +: 8] = {1'b0, (act &  val) ? sel : 7'd0};
        assign clr_bits[8*l +: 8] = {1'b0, (act & ~val) ? sel : 7'd0};
    end
endmodule

// File: rtl/sc_addr_map.sv
`timescale 1ns/1ps
module sc_addr_map #(
    parameter int NREG = 5,
    parameter int AW   = 8,
    parameter logic [NREG-1:0][AW-1:0] OFFS = '0
) (
    input  logic [AW-1:0]   addr,
    output logic [NREG-1:0] hit
);
    for (genvar i = 0; i < NREG; i++) begin : g_cmp
        assign hit[i] = (addr == OFFS[i]);
    end
endmodule

// File: rtl/sc_reg_slice.sv
`timescale 1ns/1ps
module sc_reg_slice #(
    parameter int DW = 32,
    parameter logic [DW-1:0] IMPL  = '0,
    parameter logic [DW-1:0] PULSE = '0,
    parameter logic [DW-1:0] RSTV  = '0,
    parameter logic [DW-1:0] VALM  = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic [DW-1:0] set_bits,
    input  logic [DW-1:0] clr_bits,
    output logic [DW-1:0] q
);
    localparam logic [DW-1:0] EFF   = IMPL & ~VALM;
    localparam logic [DW-1:0] PEFF  = PULSE & EFF;
    localparam logic [DW-1:0] RINIT = RSTV & EFF;

    logic [DW-1:0] held;
    logic [DW-1:0] q_n;

    always_comb begin
        held = q & ~PEFF;          // pulse bits last a single cycle
        if (sel) q_n = ((held & ~clr_bits) | set_bits) & EFF;
        else     q_n = held;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RINIT;
        else        q <= q_n;
    end
endmodule

// File: rtl/sc_read_mux.sv
`timescale 1ns/1ps
module sc_read_mux #(
    parameter int NREG = 5,
    parameter int DW   = 32
) (
    input  logic [NREG-1:0]         hit,
    input  logic [NREG-1:0][DW-1:0] regs,
    output logic [DW-1:0]           rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++)
            if (hit[i]) rdata = rdata | regs[i];
    end
endmodule

// File: rtl/sc_cmd_bank.sv
`timescale 1ns/1ps
module sc_cmd_bank
    import sc_cmd_pkg::*;
#(
    parameter int NREG = SC_NREG,
    parameter int AW   = SC_AW,
    parameter int DW   = SC_DW,
    parameter logic [NREG-1:0][AW-1:0] OFFS  = SC_DEF_OFFS,
    parameter logic [NREG-1:0][DW-1:0] MASK  = SC_DEF_MASK,
    parameter logic [NREG-1:0][DW-1:0] PULSE = SC_DEF_PULSE,
    parameter logic [NREG-1:0][DW-1:0] RSTV  = SC_DEF_RSTV,
    localparam int LANES = DW/8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [LANES-1:0] bus_be,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata
);
    localparam logic [DW-1:0] VALM = sc_value_bits();

    logic [NREG-1:0]         reg_hit;
    logic [DW-1:0]           set_bits;
    logic [DW-1:0]           clr_bits;
    logic [NREG-1:0][DW-1:0] regs_q;

    sc_addr_map #(.NREG(NREG), .AW(AW), .OFFS(OFFS)) u_map (
        .addr (bus_addr),
        .hit  (reg_hit)
    );

    sc_lane_decode #(.DW(DW)) u_dec (
        .wr_live   (bus_we),
        .lane_stb  (bus_be),
        .lane_data (bus_wdata),
        .set_bits  (set_bits),
        .clr_bits  (clr_bits)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        sc_reg_slice #(
            .DW(DW), .IMPL(MASK[i]), .PULSE(PULSE[i]), .RSTV(RSTV[i]), .VALM(VALM)
        ) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (reg_hit[i]),
            .set_bits (set_bits),
            .clr_bits (clr_bits),
            .q        (regs_q[i])
        );
    end

    sc_read_mux #(.NREG(NREG), .DW(DW)) u_rd (
        .hit   (reg_hit),
        .regs  (regs_q),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/sc_cmd_bank_chk.sv
`timescale 1ns/1ps
module sc_cmd_bank_chk #(
    parameter int NREG = 5,
    parameter int AW   = 8,
    parameter int DW   = 32,
    parameter logic [NREG-1:0][AW-1:0] OFFS  = '0,
    parameter logic [NREG-1:0][DW-1:0] MASK  = '0,
    parameter logic [NREG-1:0][DW-1:0] PULSE = '0,
    localparam int LANES = DW/8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_we,
    input logic [AW-1:0]           bus_addr,
    input logic [LANES-1:0]        bus_be,
    input logic [DW-1:0]           bus_rdata,
    input logic [NREG-1:0][DW-1:0] regs_q
);
    logic [DW-1:0] valm;
    logic          mapped;

    always_comb begin
        valm = '0;
        for (int l = 0; l < LANES; l++) valm[8*l+7] = 1'b1;
        mapped = 1'b0;
        for (int i = 0; i < NREG; i++) if (bus_addr == OFFS[i]) mapped = 1'b1;
    end

    AST_VALUE_BITS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & valm) == '0); // R7

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> bus_rdata == '0); // R11

    for (genvar i = 0; i < NREG; i++) begin : g_chk
        AST_UNIMPL_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (regs_q[i] & ~MASK[i]) == '0); // R6

        AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!bus_we || bus_be == '0) |=> $stable(regs_q[i] & ~PULSE[i])); // R5

        AST_UNMAPPED_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && !mapped) |=> $stable(regs_q[i] & ~PULSE[i])); // R11

        AST_PULSE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!bus_we && ((regs_q[i] & PULSE[i]) != '0)) |=> (regs_q[i] & PULSE[i]) == '0); // R9
    end
endmodule

bind sc_cmd_bank sc_cmd_bank_chk #(
    .NREG(NREG), .AW(AW), .DW(DW), .OFFS(OFFS), .MASK(MASK), .PULSE(PULSE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_rdata (bus_rdata),
    .regs_q    (regs_q)
);

// File: tb/sc_cmd_bank_bench.sv
`timescale 1ns/1ps
module sc_cmd_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam logic [7:0] A0 = 8'h40, A1 = 8'h48, A2 = 8'h50, A3 = 8'h54, A4 = 8'h64;

    always #2 clk = ~clk;   // 250 MHz

    sc_cmd_bank u_sc_cmd_bank (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // driver: one bus cycle, optional expected read-data for that cycle
    task automatic step(input logic we, input logic [7:0] addr, input logic [3:0] be,
                        input logic [31:0] wd, input bit chk, input logic [31:0] exp,
                        input string tag);
        @(negedge clk);
        bus_we = we; bus_addr = addr; bus_be = be; bus_wdata = wd;
        if (chk) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
    endtask

    task automatic wr(input logic [7:0] addr, input logic [3:0] be, input logic [31:0] wd);
        step(1'b1, addr, be, wd, 1'b0, '0, "");
    endtask

    task automatic rd(input logic [7:0] addr, input logic [31:0] exp, input string tag);
        step(1'b0, addr, 4'h0, '0, 1'b1, exp, tag);
    endtask

    // monitor: compares read data away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (bus_rdata !== e) begin
                    bad++;
                    $display("FAIL %s: got %08h expected %08h", t, bus_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A0, 32'h0, "R1 reg 0x40");
        rd(A1, 32'h0, "R1 reg 0x48");
        rd(A2, 32'h0, "R1 reg 0x50");
        rd(A3, 32'h0, "R1 reg 0x54");
        rd(A4, 32'h0, "R1 reg 0x64");
        // R2 set
        wr(A0, 4'b0001, 32'h0000_009A);
        rd(A0, 32'h0000_001A, "R2 set bits 1,3,4");
        wr(A0, 4'b0001, 32'h0000_0081);
        rd(A0, 32'h0000_001B, "R2 set bit 0");
        // R3 clear, R4 bit 0 kept
        wr(A0, 4'b0001, 32'h0000_001A);
        rd(A0, 32'h0000_0001, "R3 clear bits 1,3,4 / R4 bit 0 kept");
        // R4 independent lanes
        wr(A2, 4'b1111, 32'hFF7F_FF03);
        rd(A2, 32'h3F00_3F00, "R4 four lanes mixed values");
        wr(A2, 4'b0101, 32'h0081_0001);
        rd(A2, 32'h3F01_3F00, "R4 two lanes set and clear");
        // R5 strobes
        wr(A2, 4'b0000, 32'hFFFF_FFFF);
        rd(A2, 32'h3F01_3F00, "R5 no strobes");
        wr(A2, 4'b0010, 32'h00FF_00FF);
        rd(A2, 32'h3F01_3F00, "R5 unstrobed lanes ignored");
        // R6 implemented mask, R7 value bits
        wr(A4, 4'b1111, 32'hFFFF_FFFF);
        rd(A4, 32'h0000_001B, "R6 mask at 0x64");
        wr(A0, 4'b1111, 32'hFFFF_FFFF);
        rd(A0, 32'h1F7F_7F1F, "R7 value positions read 0 / R6 mask at 0x40");
        // R8 full-mask clear
        wr(A0, 4'b1111, 32'h1F7F_7F1F);
        rd(A0, 32'h0, "R8 clear all at 0x40");
        wr(A4, 4'b1111, 32'h0000_001B);
        rd(A4, 32'h0, "R8 clear all at 0x64");
        // R9 pulse bits
        wr(A1, 4'b0101, 32'h0081_0081);
        rd(A1, 32'h0001_0001, "R9 pulse visible one cycle");
        rd(A1, 32'h0000_0001, "R9 pulse gone, plain bit kept");
        wr(A1, 4'b0010, 32'h0000_8F00);
        rd(A1, 32'h0000_0F01, "R9 four pulse bits");
        rd(A1, 32'h0000_0001, "R9 four pulse bits expire");
        // R10 write in expiry cycle
        wr(A1, 4'b0010, 32'h0000_8100);
        step(1'b1, A1, 4'b0001, 32'h0000_0082, 1'b1, 32'h0000_0101, "R10 pulse seen during write");
        rd(A1, 32'h0000_0003, "R10 write applied, pulse expired");
        wr(A1, 4'b0010, 32'h0000_8100);
        wr(A1, 4'b0010, 32'h0000_8100);
        rd(A1, 32'h0000_0103, "R10 re-set pulse survives");
        rd(A1, 32'h0000_0003, "R10 re-set pulse then expires");
        // R11 unmapped
        wr(8'h44, 4'b1111, 32'hFFFF_FFFF);
        rd(8'h44, 32'h0, "R11 unmapped read");
        rd(8'h00, 32'h0, "R11 unmapped read 0x00");
        rd(A0, 32'h0, "R11 0x40 untouched");
        rd(A1, 32'h0000_0003, "R11 0x48 untouched");
        rd(A2, 32'h3F01_3F00, "R11 0x50 untouched");
        // R12 isolation
        wr(A3, 4'b1111, 32'hFFFF_FFFF);
        rd(A3, 32'h203C_7E07, "R12 0x54 written");
        rd(A2, 32'h3F01_3F00, "R12 0x50 untouched");
        rd(A4, 32'h0, "R12 0x64 untouched");
        step(1'b0, 8'h00, 4'h0, '0, 1'b0, '0, "");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule